// File: doc/BRIEF.md
# 128-bit Multimedia Lane Unit

This block widens the general register file of a MIPS-style integer core to 128 bits and adds a small execution unit that treats each register as a set of independent byte or halfword lanes. The scalar pipeline keeps using a 32-bit read and write port. That port sees and changes only bits 31:0 of each wide entry, so the scalar view and the wide view of a register never disagree.

A multimedia instruction word is presented with `op_valid`. The unit selects its operation group from the function field and the operation within that group from the shift-amount field. It reads the two source registers named by rs and rt and computes a 128-bit result. On the next clock edge it writes the result to rd and presents it on the writeback outputs for one cycle. Six operations are provided: two 64-bit copy forms, a halfword broadcast, a per-byte subtract, a bitwise NOR and a bitwise AND. A build parameter removes the wide unit altogether. In that build the storage shrinks to 32 entries of 32 bits, and multimedia words produce no writeback.

Top module: `wide_lane_unit`

## Requirements
- R1: An operation is recognised only when bits 31:26 equal 0x1C and the pair (function bits 5:0, shift-amount bits 10:6) is one of the following: PCPYLD (0x09, 0x0E), PAND (0x09, 0x12), PSUBB (0x08, 0x09), PNOR (0x29, 0x13), PCPYUD (0x29, 0x0E) or PCPYH (0x29, 0x1B). Any other word produces no writeback and changes no register. rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R2: PCPYLD yields rt[63:0] in result bits 63:0 and rs[63:0] in result bits 127:64.
- R3: PCPYUD yields rs[127:64] in result bits 63:0 and rt[127:64] in result bits 127:64.
- R4: PCPYH copies rt[15:0] into each of the four halfwords of result bits 63:0, and copies rt[79:64] into each of the four halfwords of result bits 127:64.
- R5: PSUBB computes, for each of the 16 bytes, rs byte minus rt byte modulo 256. No borrow passes between bytes.
- R6: PNOR yields the bitwise NOR of rs and rt over all 128 bits.
- R7: PAND yields the bitwise AND of rs and rt over all 128 bits.
- R8: A recognised operation sampled with `op_valid` at a clock edge raises `wb_valid` for exactly the following cycle. In that cycle `wb_rd` holds rd and `wb_data` holds the result, and the result has already been written to register rd.
- R9: `scalar_rdata` always equals bits 31:0 of the entry named by `scalar_raddr`. A scalar write replaces bits 31:0 only and leaves bits 127:32 of the entry unchanged.
- R10: Register 0 reads as all zeros on every port, and writes to it from either port are discarded.
- R11: After reset every register is zero in all 128 bits and `wb_valid` is low.
- R12: With ENABLE_WIDE = 0 the storage is 32 entries of 32 bits. `wb_valid` never rises, and the scalar port behaves as a plain 32-bit register file.
- R13: When a scalar write and a wide writeback target the same register at the same edge, the wide result is stored in all 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_word | input | 32 | Instruction word carrying opcode, rs, rt, rd, shift amount and function |
| scalar_we | input | 1 | Scalar write enable |
| scalar_waddr | input | 5 | Scalar write register index |
| scalar_wdata | input | 32 | Scalar write data for bits 31:0 |
| scalar_raddr | input | 5 | Scalar read register index |
| scalar_rdata | output | 32 | Bits 31:0 of the addressed register |
| wb_valid | output | 1 | Writeback present |
| wb_rd | output | 5 | Writeback destination register |
| wb_data | output | 128 | Writeback result |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with ENABLE_WIDE = 1 and one with ENABLE_WIDE = 0. This lets every scalar access be compared against both the wide and the narrow storage in the same run. The wide build is swept over all six operations and every rs/rt pair of the 32 registers. Results feed back into later sources, so upper-half data created by the copy and broadcast forms is exercised by the lane operations that follow. Directed cases cover byte lanes at 0x00, 0x80 and 0xFF, writes to register 0, words that miss the decode table by a single field, and a scalar write that collides with a wide writeback.

// File: rtl/wide_lane_pkg.sv
package wide_lane_pkg;

    localparam int XLEN = 32;
    localparam int WLEN = 128;
    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);

    localparam logic [5:0] MM_OPCODE = 6'h1C;
    localparam logic [5:0] FN_GRP0   = 6'h08;
    localparam logic [5:0] FN_GRP2   = 6'h09;
    localparam logic [5:0] FN_GRP3   = 6'h29;

    localparam logic [4:0] SA_SUBB  = 5'h09;
    localparam logic [4:0] SA_CPYLD = 5'h0E;
    localparam logic [4:0] SA_AND   = 5'h12;
    localparam logic [4:0] SA_NOR   = 5'h13;
    localparam logic [4:0] SA_CPYUD = 5'h0E;
    localparam logic [4:0] SA_CPYH  = 5'h1B;

    typedef enum logic [2:0] {
        LOP_NONE,
        LOP_CPYLD,
        LOP_CPYUD,
        LOP_CPYH,
        LOP_SUBB,
        LOP_NOR,
        LOP_AND
    } lane_op_e;

    typedef struct packed {
        logic [5:0]    opcode;
        logic [AW-1:0] rs;
        logic [AW-1:0] rt;
        logic [AW-1:0] rd;
        logic [4:0]    sa;
        logic [5:0]    funct;
    } instr_fields_t;

    typedef struct packed {
        lane_op_e      op;
        logic [AW-1:0] rs;
        logic [AW-1:0] rt;
        logic [AW-1:0] rd;
    } lane_cmd_t;

    function automatic lane_op_e classify(instr_fields_t f);
        lane_op_e r;
        r = LOP_NONE;
        if (f.opcode == MM_OPCODE) begin
            unique case (f.funct)
                FN_GRP0: if (f.sa == SA_SUBB) r = LOP_SUBB;
                FN_GRP2: begin
                    if (f.sa == SA_CPYLD)    r = LOP_CPYLD;
                    else if (f.sa == SA_AND) r = LOP_AND;
                end
                FN_GRP3: begin
                    if (f.sa == SA_NOR)        r = LOP_NOR;
                    else if (f.sa == SA_CPYUD) r = LOP_CPYUD;
                    else if (f.sa == SA_CPYH)  r = LOP_CPYH;
                end
                default: r = LOP_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/wide_lane_decode.sv
module wide_lane_decode
    import wide_lane_pkg::*;
(
    input  logic [31:0] op_word,
    output lane_cmd_t   cmd
);
    instr_fields_t f;

    always_comb begin
        f      = instr_fields_t'(op_word);
        cmd.op = classify(f);
        cmd.rs = f.rs;
        cmd.rt = f.rt;
        cmd.rd = f.rd;
    end
endmodule

// File: rtl/wide_lane_alu.sv
module wide_lane_alu
    import wide_lane_pkg::*;
#(
    parameter int W = WLEN
) (
    input  lane_op_e       op,
    input  logic [W-1:0]   src_s,
    input  logic [W-1:0]   src_t,
    output logic [W-1:0]   result
);
    localparam int HALF  = W / 2;
    localparam int NBYTE = W / 8;
    localparam int NHW   = W / 16;

    logic [W-1:0] byte_diff;
    logic [W-1:0] hw_bcast;

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign byte_diff[g*8 +: 8] = src_s[g*8 +: 8] - src_t[g*8 +: 8];
    end

    for (genvar h = 0; h < NHW; h++) begin : g_hw
        if (h < NHW / 2) begin : g_lo
            assign hw_bcast[h*16 +: 16] = src_t[15:0];
        end else begin : g_hi
            assign hw_bcast[h*16 +: 16] = src_t[HALF +: 16];
        end
    end

    always_comb begin
        unique case (op)
            LOP_CPYLD: result = {src_s[HALF-1:0], src_t[HALF-1:0]};
            LOP_CPYUD: result = {src_t[W-1:HALF], src_s[W-1:HALF]};
            LOP_CPYH:  result = hw_bcast;
            LOP_SUBB:  result = byte_diff;
            LOP_NOR:   result = ~(src_s | src_t);
            LOP_AND:   result = src_s & src_t;
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/wide_lane_regfile.sv
module wide_lane_regfile
    import wide_lane_pkg::*;
#(
    parameter int ENABLE_WIDE = 1,
    parameter int X = XLEN,
    parameter int W = WLEN,
    parameter int N = NREG,
    localparam int A = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [A-1:0] rd_a_addr,
    input  logic [A-1:0] rd_b_addr,
    output logic [W-1:0] rd_a_data,
    output logic [W-1:0] rd_b_data,
    input  logic [A-1:0] sc_raddr,
    output logic [X-1:0] sc_rdata,
    input  logic         sc_we,
    input  logic [A-1:0] sc_waddr,
    input  logic [X-1:0] sc_wdata,
    input  logic         wd_we,
    input  logic [A-1:0] wd_waddr,
    input  logic [W-1:0] wd_wdata
);
    if (ENABLE_WIDE != 0) begin : g_wide
        logic [W-1:0] mem [N];

        always_ff @(posedge clk) begin
            for (int i = 0; i < N; i++) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (i != 0) begin
                    if (wd_we && wd_waddr == A'(i))
                        mem[i] <= wd_wdata;
                    else if (sc_we && sc_waddr == A'(i))
                        mem[i][X-1:0] <= sc_wdata;
                end
            end
        end

        assign rd_a_data = (rd_a_addr == '0) ? '0 : mem[rd_a_addr];
        assign rd_b_data = (rd_b_addr == '0) ? '0 : mem[rd_b_addr];
        assign sc_rdata  = (sc_raddr == '0) ? '0 : mem[sc_raddr][X-1:0];
    end else begin : g_narrow
        logic [X-1:0] mem [N];
        logic         unused_wide;

        always_ff @(posedge clk) begin
            for (int i = 0; i < N; i++) begin
                if (rst)
                    mem[i] <= '0;
                else if (i != 0 && sc_we && sc_waddr == A'(i))
                    mem[i] <= sc_wdata;
            end
        end

        assign unused_wide = ^{wd_we, wd_waddr, wd_wdata};
        assign rd_a_data   = (rd_a_addr == '0) ? '0 : {{(W-X){1'b0}}, mem[rd_a_addr]};
        assign rd_b_data   = (rd_b_addr == '0) ? '0 : {{(W-X){1'b0}}, mem[rd_b_addr]};
        assign sc_rdata    = (sc_raddr == '0) ? '0 : mem[sc_raddr];
    end
endmodule

// File: rtl/wide_lane_unit.sv
module wide_lane_unit
    import wide_lane_pkg::*;
#(
    parameter int ENABLE_WIDE = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [31:0]     op_word,
    input  logic            scalar_we,
    input  logic [AW-1:0]   scalar_waddr,
    input  logic [XLEN-1:0] scalar_wdata,
    input  logic [AW-1:0]   scalar_raddr,
    output logic [XLEN-1:0] scalar_rdata,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_rd,
    output logic [WLEN-1:0] wb_data
);
    lane_cmd_t       cmd;
    logic [WLEN-1:0] val_s;
    logic [WLEN-1:0] val_t;
    logic [WLEN-1:0] lane_out;
    logic            hit;

    wide_lane_decode u_dec (
        .op_word (op_word),
        .cmd     (cmd)
    );

    wide_lane_regfile #(
        .ENABLE_WIDE (ENABLE_WIDE)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_addr (cmd.rs),
        .rd_b_addr (cmd.rt),
        .rd_a_data (val_s),
        .rd_b_data (val_t),
        .sc_raddr  (scalar_raddr),
        .sc_rdata  (scalar_rdata),
        .sc_we     (scalar_we),
        .sc_waddr  (scalar_waddr),
        .sc_wdata  (scalar_wdata),
        .wd_we     (hit),
        .wd_waddr  (cmd.rd),
        .wd_wdata  (lane_out)
    );

    wide_lane_alu u_alu (
        .op     (cmd.op),
        .src_s  (val_s),
        .src_t  (val_t),
        .result (lane_out)
    );

    assign hit = op_valid && (ENABLE_WIDE != 0) && (cmd.op != LOP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= hit;
            if (hit) begin
                wb_rd   <= cmd.rd;
                wb_data <= lane_out;
            end
        end
    end
endmodule

// File: rtl/wide_lane_checker.sv
module wide_lane_checker
    import wide_lane_pkg::*;
#(
    parameter int ENABLE_WIDE = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [31:0]     op_word,
    input logic [AW-1:0]   scalar_raddr,
    input logic [XLEN-1:0] scalar_rdata,
    input logic            wb_valid,
    input logic [AW-1:0]   wb_rd,
    input logic [WLEN-1:0] wb_data
);
    p_wb_needs_op_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(op_valid));

    p_wb_dest_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_rd == $past(op_word[15:11])));

    p_undecoded_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_word[31:26] != MM_OPCODE) |=> !wb_valid);

    p_zero_reg_r10: assert property (@(posedge clk) disable iff (rst)
        (scalar_raddr == '0) |-> (scalar_rdata == '0));

    p_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_rd == scalar_raddr && wb_rd != '0)
            |-> (scalar_rdata == wb_data[XLEN-1:0]));

    p_narrow_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_WIDE == 0) |-> !wb_valid);
endmodule

bind wide_lane_unit wide_lane_checker #(.ENABLE_WIDE(ENABLE_WIDE)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_word      (op_word),
    .scalar_raddr (scalar_raddr),
    .scalar_rdata (scalar_rdata),
    .wb_valid     (wb_valid),
    .wb_rd        (wb_rd),
    .wb_data      (wb_data)
);

// File: tb/wide_lane_unit_tb_top.sv
`timescale 1ns/1ps
module wide_lane_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [31:0]  op_word = '0;
    logic         scalar_we = 1'b0;
    logic [4:0]   scalar_waddr = '0;
    logic [31:0]  scalar_wdata = '0;
    logic [4:0]   scalar_raddr = '0;

    logic [31:0]  w_rdata, n_rdata;
    logic         w_wbv, n_wbv;
    logic [4:0]   w_wbrd, n_wbrd;
    logic [127:0] w_wbd, n_wbd;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [127:0] model  [32];
    logic [31:0]  nmodel [32];

    always #4 clk = ~clk;

    wide_lane_unit #(.ENABLE_WIDE(1)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .scalar_we(scalar_we), .scalar_waddr(scalar_waddr), .scalar_wdata(scalar_wdata),
        .scalar_raddr(scalar_raddr), .scalar_rdata(w_rdata),
        .wb_valid(w_wbv), .wb_rd(w_wbrd), .wb_data(w_wbd)
    );

    wide_lane_unit #(.ENABLE_WIDE(0)) dut_narrow_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .scalar_we(scalar_we), .scalar_waddr(scalar_waddr), .scalar_wdata(scalar_wdata),
        .scalar_raddr(scalar_raddr), .scalar_rdata(n_rdata),
        .wb_valid(n_wbv), .wb_rd(n_wbrd), .wb_data(n_wbd)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // op index: 0 CPYLD, 1 CPYUD, 2 CPYH, 3 SUBB, 4 NOR, 5 AND
    function automatic logic [31:0] mkword(int k, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        logic [5:0] fn;
        logic [4:0] sa;
        case (k)
            0: begin fn = 6'h09; sa = 5'h0E; end
            1: begin fn = 6'h29; sa = 5'h0E; end
            2: begin fn = 6'h29; sa = 5'h1B; end
            3: begin fn = 6'h08; sa = 5'h09; end
            4: begin fn = 6'h29; sa = 5'h13; end
            default: begin fn = 6'h09; sa = 5'h12; end
        endcase
        return {6'h1C, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [127:0] expect_op(int k, logic [127:0] a, logic [127:0] b);
        logic [127:0] y;
        y = '0;
        case (k)
            0: y = {a[63:0], b[63:0]};
            1: y = {b[127:64], a[127:64]};
            2: for (int h = 0; h < 8; h++) y[h*16 +: 16] = (h < 4) ? b[15:0] : b[79:64];
            3: for (int i = 0; i < 16; i++) y[i*8 +: 8] = 8'((int'(a[i*8 +: 8]) + 256 - int'(b[i*8 +: 8])) % 256);
            4: y = ~(a | b);
            default: y = a & b;
        endcase
        return y;
    endfunction

    function automatic string req_of(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic scalar_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        scalar_we = 1'b1; scalar_waddr = a; scalar_wdata = d;
        @(posedge clk);
        if (a != 0) begin
            model[a][31:0] = d;
            nmodel[a] = d;
        end
        @(negedge clk);
        scalar_we = 1'b0;
    endtask

    // issue one operation, check writeback, mirror (R9) and narrow build (R12)
    task automatic run_op(input int k, input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
        logic [127:0] exp;
        @(negedge clk);
        exp = expect_op(k, model[rs], model[rt]);
        op_valid = 1'b1;
        op_word  = mkword(k, rs, rt, rd);
        @(posedge clk);
        if (rd != 0) model[rd] = exp;
        @(negedge clk);
        op_valid = 1'b0;
        scalar_raddr = rd;
        #1;
        check(w_wbv && w_wbrd == rd && w_wbd == exp, {req_of(k), "/R8 writeback"}, w_wbd, exp);
        check(w_rdata == model[rd][31:0], "R9 scalar mirror after wide write", 128'(w_rdata), model[rd]);
        check(!n_wbv, "R12 narrow build writeback", 128'(n_wbv), 128'(0));
        check(n_rdata == nmodel[rd], "R12 narrow scalar view", 128'(n_rdata), 128'(nmodel[rd]));
    endtask

    task automatic run_bad(input logic [31:0] w, input logic [4:0] rd);
        @(negedge clk);
        op_valid = 1'b1; op_word = w;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; scalar_raddr = rd;
        #1;
        check(!w_wbv, "R1 undecoded word gives no writeback", 128'(w_wbv), 128'(0));
        check(w_rdata == model[rd][31:0], "R1 undecoded word leaves rd", 128'(w_rdata), model[rd]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] exp;
        for (int i = 0; i < 32; i++) begin model[i] = '0; nmodel[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        #1;
        check(!w_wbv && !n_wbv, "R11 wb_valid low after reset", 128'(w_wbv), 128'(0));
        for (int i = 0; i < 32; i++) begin
            scalar_raddr = 5'(i);
            #1;
            check(w_rdata == 0 && n_rdata == 0, "R11 scalar view zero after reset", 128'(w_rdata), 128'(0));
        end
        run_op(1, 5'd3, 5'd4, 5'd9);
        check(w_wbd == '0, "R11 upper halves zero after reset", w_wbd, 128'(0));

        // R5 byte lane boundaries
        scalar_write(5'd5, 32'hFF018000);
        scalar_write(5'd6, 32'h01010101);
        run_op(3, 5'd5, 5'd6, 5'd7);
        check(w_wbd == 128'h0000_0000_0000_0000_0000_0000_FE00_7FFF, "R5 no borrow between bytes",
              w_wbd, 128'h0000_0000_0000_0000_0000_0000_FE00_7FFF);

        // R9 scalar write keeps upper bits
        run_op(0, 5'd5, 5'd6, 5'd8);
        scalar_write(5'd8, 32'hA5A5_5A5A);
        run_op(0, 5'd0, 5'd8, 5'd10);
        exp = {64'h0, 32'h0, 32'hA5A5_5A5A};
        check(w_wbd == exp, "R9 scalar write keeps bits 63:32", w_wbd, exp);
        run_op(1, 5'd8, 5'd0, 5'd11);
        exp = {64'h0, 64'h0000_0000_FF01_8000};
        check(w_wbd == exp, "R9 scalar write keeps bits 127:64", w_wbd, exp);

        // seed all registers
        for (int i = 1; i < 32; i++)
            scalar_write(5'(i), 32'(i) * 32'h0913_5A27 + 32'h7C3E_B1D5);

        // R10 write to register 0 discarded
        run_op(4, 5'd3, 5'd4, 5'd0);
        scalar_raddr = 5'd0;
        #1;
        check(w_rdata == 0, "R10 register 0 after wide write", 128'(w_rdata), 128'(0));
        scalar_write(5'd0, 32'hDEAD_BEEF);
        run_op(4, 5'd0, 5'd0, 5'd12);
        check(w_wbd == {128{1'b1}}, "R10 register 0 reads zero on wide port", w_wbd, {128{1'b1}});

        // sweep every op over every rs/rt pair
        for (int rs = 0; rs < 32; rs++)
            for (int rt = 0; rt < 32; rt++)
                for (int k = 0; k < 6; k++)
                    run_op(k, 5'(rs), 5'(rt), 5'((rs + rt * 5 + k * 11 + 1) % 32));

        // R1 near-miss words
        run_bad({6'h1D, 5'd1, 5'd2, 5'd13, 5'h0E, 6'h09}, 5'd13);
        run_bad({6'h1C, 5'd1, 5'd2, 5'd13, 5'h0E, 6'h0A}, 5'd13);
        run_bad({6'h1C, 5'd1, 5'd2, 5'd13, 5'h0F, 6'h09}, 5'd13);
        run_bad({6'h1C, 5'd1, 5'd2, 5'd13, 5'h0E, 6'h08}, 5'd13);
        run_bad({6'h1C, 5'd1, 5'd2, 5'd13, 5'h09, 6'h29}, 5'd13);

        // R13 collision
        @(negedge clk);
        exp = expect_op(5, model[14], model[15]);
        op_valid = 1'b1; op_word = mkword(5, 5'd14, 5'd15, 5'd7);
        scalar_we = 1'b1; scalar_waddr = 5'd7; scalar_wdata = 32'h1357_9BDF;
        @(posedge clk);
        model[7] = exp;
        nmodel[7] = 32'h1357_9BDF;
        @(negedge clk);
        op_valid = 1'b0; scalar_we = 1'b0;
        run_op(1, 5'd7, 5'd0, 5'd16);
        check(w_wbd[63:0] == exp[127:64], "R13 wide result kept upper half", w_wbd, {64'h0, exp[127:64]});
        scalar_raddr = 5'd7;
        #1;
        check(w_rdata == exp[31:0], "R13 wide result wins low word", 128'(w_rdata), 128'(exp[31:0]));
        check(n_rdata == 32'h1357_9BDF, "R12 narrow build takes scalar write", 128'(n_rdata), 128'(32'h1357_9BDF));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule